// File: doc/BRIEF.md
# Hex-ASCII Telemetry Serial Transmitter

This block sends a 16-bit internal value to a host terminal as readable text. The value comes from one of four sources: the controller output, the measured encoder position, the commanded profile position or the position error. A 2-bit select picks the source. When a send request is accepted, the selected word is captured. It then goes out on an asynchronous serial line as four hexadecimal ASCII characters, most significant nibble first, followed by a carriage return.

Bit timing comes from an external one-cycle baud tick, produced by the same divider that serves the receive side. Every line transition happens on a tick. The five characters of a message leave back to back with no idle gap between frames. A busy output covers the whole message, from capture until the carriage return's stop bit ends.

Top module: `hex_telemetry_tx`

## Requirements
- R1: Select value 0 picks the controller output, 1 the encoder position, 2 the profile position and 3 the position error.
- R2: The selected word is captured in the cycle the request is accepted. Later changes to the sources or to the select do not alter the message in progress.
- R3: A message is four characters, one per nibble with the most significant nibble first, followed by the carriage return 0x0D.
- R4: Nibble values 0 to 9 are sent as 0x30 to 0x39, and values 10 to 15 are sent as uppercase 0x41 to 0x46.
- R5: Each character is framed 8N1: one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts exactly one baud-tick interval. The line changes only in the cycle after a tick. The frames of one message follow each other with no idle bit between them.
- R6: Busy rises one cycle after an accepted request. It falls on the tick edge where the carriage return's stop bit ends, ten bit times after that character's start bit began.
- R7: A send request that arrives while busy is high is ignored and causes no extra characters.
- R8: After reset the line is high and busy is low. The line stays high whenever no message is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| ctrl_out_word | input | 16 | Controller output source (select 0) |
| enc_pos_word | input | 16 | Encoder position source (select 1) |
| prof_pos_word | input | 16 | Profile position source (select 2) |
| err_word | input | 16 | Position error source (select 3) |
| src_sel | input | 2 | Source select |
| send_req | input | 1 | Request to send one message |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | High while a message is in progress |

## Verification
The hardest case to reach from the ports is a request, together with a change of sources and select, while a message is in flight. The capture would have to be overwritten silently mid-message. The bench raises the request again and moves every source and the select partway through a message. It then decodes the line and compares each character against the snapshot taken at acceptance. The handover from one frame's stop bit to the next start bit is checked by timing consecutive start edges, which must be exactly ten bit periods apart.

// File: rtl/hex_tx_pkg.sv
package hex_tx_pkg;
    localparam int CHAR_W     = 8;
    localparam int NIB_W      = 4;
    localparam int FRAME_BITS = CHAR_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CHAR_W-1:0] CR_CHAR = 8'h0D;

    // Map one nibble to its uppercase hex ASCII code.
    function automatic logic [CHAR_W-1:0] nib_to_ascii(input logic [NIB_W-1:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;    // 0 = idle, 1..FRAME_BITS = bit on line
        logic [CHAR_W:0]   shreg;  // remaining data bits plus stop bit
        logic              line;
    } ser_st_t;
endpackage

// File: rtl/hex_tx_src_mux.sv
module hex_tx_src_mux #(
    parameter int SRC_N  = 4,
    parameter int WORD_W = 16,
    localparam int SEL_W = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0][WORD_W-1:0] src_bus,
    input  logic [SEL_W-1:0]             sel,
    output logic [WORD_W-1:0]            word
);
    logic [SRC_N-1:0][WORD_W-1:0] masked;

    for (genvar g = 0; g < SRC_N; g++) begin : g_lane
        assign masked[g] = (sel == SEL_W'(g)) ? src_bus[g] : '0;
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < SRC_N; i++) word = word | masked[i];
    end
endmodule

// File: rtl/hex_tx_msg_ctrl.sv
module hex_tx_msg_ctrl
    import hex_tx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [WORD_W-1:0] word_in,
    input  logic              take,
    input  logic              frame_end,
    output logic              busy,
    output logic              have_byte,
    output logic [CHAR_W-1:0] char_byte
);
    localparam int NIB_N = WORD_W / NIB_W;
    localparam int IDX_W = $clog2(NIB_N + 2);
    localparam logic [IDX_W-1:0] CR_IDX   = IDX_W'(NIB_N);
    localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(NIB_N + 1);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] work;
    } msg_st_t;

    msg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (send_req) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.work = word_in;
            end
        end else begin
            if (take) begin
                st_d.idx  = st_q.idx + 1'b1;
                st_d.work = st_q.work << NIB_W;
            end
            if (frame_end && st_q.idx == DONE_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign have_byte = st_q.busy && (st_q.idx <= CR_IDX);
    assign char_byte = (st_q.idx < CR_IDX) ? nib_to_ascii(st_q.work[WORD_W-1 -: NIB_W])
                                           : CR_CHAR;
endmodule

// File: rtl/hex_tx_uart_ser.sv
module hex_tx_uart_ser
    import hex_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              have_byte,
    input  logic [CHAR_W-1:0] byte_in,
    output logic              take,
    output logic              frame_end,
    output logic              tx_line
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

    ser_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        take      = 1'b0;
        frame_end = 1'b0;
        if (baud_tick) begin
            if (st_q.cnt == '0 || st_q.cnt == LAST_CNT) begin
                frame_end = (st_q.cnt == LAST_CNT);
                if (have_byte) begin
                    st_d.shreg = {1'b1, byte_in};
                    st_d.line  = 1'b0;
                    st_d.cnt   = CNT_W'(1);
                    take       = 1'b1;
                end else begin
                    st_d.line = 1'b1;
                    st_d.cnt  = '0;
                end
            end else begin
                st_d.line  = st_q.shreg[0];
                st_d.shreg = {1'b1, st_q.shreg[CHAR_W:1]};
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0, shreg: '1, line: 1'b1};
        else        st_q <= st_d;
    end

    assign tx_line = st_q.line;
endmodule

// File: rtl/hex_telemetry_tx.sv
module hex_telemetry_tx
    import hex_tx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [WORD_W-1:0] ctrl_out_word,
    input  logic [WORD_W-1:0] enc_pos_word,
    input  logic [WORD_W-1:0] prof_pos_word,
    input  logic [WORD_W-1:0] err_word,
    input  logic [1:0]        src_sel,
    input  logic              send_req,
    output logic              tx_line,
    output logic              busy
);
    localparam int SRC_N = 4;

    logic [SRC_N-1:0][WORD_W-1:0] src_bus;
    logic [WORD_W-1:0]            sel_word;
    logic                         have_byte, take, frame_end;
    logic [CHAR_W-1:0]            char_byte;

    assign src_bus[0] = ctrl_out_word;
    assign src_bus[1] = enc_pos_word;
    assign src_bus[2] = prof_pos_word;
    assign src_bus[3] = err_word;

    hex_tx_src_mux #(.SRC_N(SRC_N), .WORD_W(WORD_W)) i_mux (
        .src_bus (src_bus),
        .sel     (src_sel),
        .word    (sel_word)
    );

    hex_tx_msg_ctrl #(.WORD_W(WORD_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_req  (send_req),
        .word_in   (sel_word),
        .take      (take),
        .frame_end (frame_end),
        .busy      (busy),
        .have_byte (have_byte),
        .char_byte (char_byte)
    );

    hex_tx_uart_ser i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .have_byte (have_byte),
        .byte_in   (char_byte),
        .take      (take),
        .frame_end (frame_end),
        .tx_line   (tx_line)
    );
endmodule

// File: rtl/hex_telemetry_tx_checker.sv
module hex_telemetry_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic send_req,
    input logic busy,
    input logic tx_line
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);                                   // R8
    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_line));                     // R5
    AST_BUSY_RISE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(send_req));                     // R6
    AST_BUSY_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));                    // R6
    AST_START_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_line) |-> busy);                             // R7
endmodule

bind hex_telemetry_tx hex_telemetry_tx_checker i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .send_req  (send_req),
    .busy      (busy),
    .tx_line   (tx_line)
);

// File: tb/test_hex_telemetry_tx.sv
module test_hex_telemetry_tx;
    localparam int TICK_DIV = 8;
    localparam int HALF     = TICK_DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic [15:0] w_ctrl = '0, w_enc = '0, w_prof = '0, w_err = '0;
    logic [1:0]  src_sel = '0;
    logic        send_req = 1'b0;
    logic        tx_line, busy;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int last_start = 0;
    int tdiv = 0;

    typedef struct { logic [7:0] ch; bit first; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hex_telemetry_tx i_hex_telemetry_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .ctrl_out_word(w_ctrl), .enc_pos_word(w_enc),
        .prof_pos_word(w_prof), .err_word(w_err),
        .src_sel(src_sel), .send_req(send_req),
        .tx_line(tx_line), .busy(busy)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv      = 0;
            baud_tick = 1'b0;
        end else begin
            baud_tick = (tdiv == TICK_DIV - 1);
            tdiv      = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
    endfunction

    // Driver: sets the sources, raises one request and pushes the expected characters.
    task automatic send_msg(input logic [1:0] sel, input logic [15:0] val, input bit disturb);
        @(negedge clk);
        w_ctrl = (sel == 2'd0) ? val : val ^ 16'h1111;
        w_enc  = (sel == 2'd1) ? val : val ^ 16'h2222;
        w_prof = (sel == 2'd2) ? val : val ^ 16'h4444;
        w_err  = (sel == 2'd3) ? val : val ^ 16'h8888;
        src_sel  = sel;
        send_req = 1'b1;
        for (int i = 3; i >= 0; i--) sb.push_back('{hex_char(val[i*4 +: 4]), i == 3});
        sb.push_back('{8'h0D, 1'b0});
        @(negedge clk);
        send_req = 1'b0;
        check(busy == 1'b1, "R6", "busy after accepted request", busy, 1);
        if (disturb) begin
            w_ctrl = 16'hDEAD; w_enc = 16'hDEAD; w_prof = 16'hDEAD; w_err = 16'hDEAD;
            src_sel = sel + 2'd1;
            repeat (30) @(negedge clk);
            send_req = 1'b1;   // R2 and R7: change everything and ask again mid-message
            repeat (3) @(negedge clk);
            send_req = 1'b0;
        end
        while (busy) @(negedge clk);
        check(cyc - last_start == 10 * TICK_DIV, "R6", "busy fall after CR start",
              cyc - last_start, 10 * TICK_DIV);
        check(tx_line == 1'b1, "R8", "line high after message", tx_line, 1);
        repeat (20) @(negedge clk);
    endtask

    // Monitor: decodes frames on the line and compares against the scoreboard.
    initial begin
        logic prev = 1'b1;
        logic [7:0] rx;
        exp_t e;
        int st;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (prev && !tx_line) begin
                st = cyc;
                repeat (HALF) @(negedge clk);
                check(tx_line == 1'b0, "R5", "start bit low", tx_line, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (TICK_DIV) @(negedge clk);
                    rx[i] = tx_line;
                end
                repeat (TICK_DIV) @(negedge clk);
                check(tx_line == 1'b1, "R5", "stop bit high", tx_line, 1);
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected character", rx, 0);
                end else begin
                    e = sb.pop_front();
                    check(rx == e.ch, "R3 R4 R1 R2", "received character", rx, e.ch);
                    if (!e.first)
                        check(st - last_start == 10 * TICK_DIV, "R5", "back-to-back frame spacing",
                              st - last_start, 10 * TICK_DIV);
                end
                last_start = st;
                prev = 1'b1;
            end else begin
                prev = tx_line;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_line == 1'b1, "R8", "line high in reset", tx_line, 1);
        check(busy == 1'b0, "R8", "busy low in reset", busy, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(tx_line == 1'b1 && busy == 1'b0, "R8", "idle without request", {busy, tx_line}, 1);

        send_msg(2'd0, 16'h1234, 1'b0);  // R1 select 0
        send_msg(2'd1, 16'hBEEF, 1'b0);  // R1 select 1, R4 letters
        send_msg(2'd2, 16'h09AF, 1'b1);  // R4 boundaries, R2 and R7 disturbance
        send_msg(2'd3, 16'hFFFF, 1'b1);  // R1 select 3
        send_msg(2'd0, 16'h0000, 1'b0);  // R4 zero digits
        send_msg(2'd2, 16'h7A5C, 1'b1);

        repeat (200) @(negedge clk);
        check(sb.size() == 0, "R3", "all expected characters received", sb.size(), 0);
        check(tx_line == 1'b1, "R7", "no frame after ignored requests", tx_line, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule